// File: doc/BRIEF.md
# Periodic Time-Slot Frame Trigger

This block paces the transmission of short anti-collision frames on a contactless reader link. When a reader command finishes, the block loads a 9-bit slot period into a down counter. It then counts encoder clock ticks. At the end of each period it emits a one-cycle send-start pulse, but only if the transmit FIFO holds data. It then reloads the counter at once, so every slot boundary stays a whole number of periods after the command finished.

The period is formed from an 8-bit low value and a separate top bit. When the low byte is zero, automatic triggering is off. The period inputs are sampled only when the counter loads or reloads, so software may rewrite them at any time. A new rewrite takes hold at the next restart. A new command start cancels the slot sequence.

The controller has two states. **IDLE** means no slot timing is active. **RUN** means the counter is timing a slot. The transitions are:
- *ARM* (IDLE→RUN): a command finishes while the low byte is nonzero.
- *RELOAD* (RUN→RUN): a period ends with a nonzero low byte, or a command finishes during a run.
- *HALT* (RUN→IDLE): a period ends with a zero low byte, or a command finishes with a zero low byte.
- *ABORT* (RUN→IDLE): a command starts.

Top module: `slot_pace_trigger`

## Requirements
- R1: The reset is synchronous and active high. After a clock edge with `rst` high, `slot_running` is 0 and `send_start` is 0.
- R2: A `cmd_done` pulse arms the counter only when `period_lo` is nonzero. A zero `period_lo` leaves the block idle, even when `period_msb` is 1.
- R3: Let P be the period that was loaded. `send_start` is high only during the clock cycle that carries the P-th `tick_en` after the load. It is high for that one clock cycle and no other.
- R4: While the block runs, consecutive period ends are exactly P ticks apart.
- R5: At a period end, `send_start` is high only if `fifo_nonempty` is 1 in that cycle. If the FIFO is empty, no pulse is produced.
- R6: At every period end with a nonzero `period_lo`, the counter reloads by itself. This happens whether or not a frame was sent.
- R7: The counter advances only on cycles where `tick_en` is 1.
- R8: The period inputs are sampled only at a load or a reload. A change during a period first affects the following period.
- R9: The period is P = 256·`period_msb` + `period_lo`. For example, 0x1BF gives 447 ticks.
- R10: A period end with `period_lo` equal to 0 stops the block. `slot_running` is 0 from the next cycle, and no further pulses are produced.
- R11: `cmd_start` forces IDLE at the next edge and blocks any pulse in its own cycle. It overrides a `cmd_done` that arrives in the same cycle.
- R12: A `cmd_done` during a run restarts the count with the current period inputs and blocks any pulse in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Encoder clock enable, one per encoder tick |
| cmd_start | input | 1 | A new command begins; cancels slot timing |
| cmd_done | input | 1 | The current command has finished executing |
| fifo_nonempty | input | 1 | The transmit FIFO holds at least one byte |
| period_lo | input | 8 | Low byte of the slot period |
| period_msb | input | 1 | Top (ninth) bit of the slot period |
| send_start | output | 1 | One-cycle request to start a frame |
| slot_running | output | 1 | The slot counter is active |

## Verification
A wrong remaining count shows up as a pulse that arrives early or late. It appears no later than the end of the period in progress. A wrong state appears in the very next cycle as a mismatch on `slot_running`. A mistake in sampling the period, or in gating by the FIFO, shows up at the next period end as a missing, extra or shifted pulse. The reference model compares both outputs in every cycle, so the first such divergence is caught in the cycle where it occurs.

// File: rtl/slot_pace_pkg.sv
package slot_pace_pkg;

    typedef enum logic [0:0] {
        SP_IDLE = 1'b0,
        SP_RUN  = 1'b1
    } sp_state_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic dec;
    } cnt_ctrl_t;

endpackage

// File: rtl/slot_pace_counter.sv
module slot_pace_counter
    import slot_pace_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] remain,
    output logic             last
);

    // clear beats load beats decrement
    always_ff @(posedge clk) begin
        if (rst || ctrl.clear) begin
            remain <= '0;
        end else if (ctrl.load) begin
            remain <= load_val;
        end else if (ctrl.dec) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign last = (remain == CNT_W'(1));

endmodule

// File: rtl/slot_pace_fsm.sv
module slot_pace_fsm
    import slot_pace_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_en,
    input  logic      cmd_start,
    input  logic      cmd_done,
    input  logic      fifo_nonempty,
    input  logic      period_ok,
    input  logic      last,
    output cnt_ctrl_t ctrl,
    output logic      fire,
    output logic      running
);

    sp_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ctrl    = '0;
        fire    = 1'b0;
        unique case (state_q)
            SP_IDLE: begin
                if (cmd_start) begin
                    ctrl.clear = 1'b1;
                end else if (cmd_done && period_ok) begin
                    ctrl.load = 1'b1;          // ARM
                    state_d   = SP_RUN;
                end
            end
            SP_RUN: begin
                if (cmd_start) begin
                    ctrl.clear = 1'b1;         // ABORT
                    state_d    = SP_IDLE;
                end else if (cmd_done) begin
                    if (period_ok) begin
                        ctrl.load = 1'b1;      // RELOAD on new completion
                    end else begin
                        ctrl.clear = 1'b1;     // HALT
                        state_d    = SP_IDLE;
                    end
                end else if (tick_en && last) begin
                    fire = fifo_nonempty;
                    if (period_ok) begin
                        ctrl.load = 1'b1;      // RELOAD at slot end
                    end else begin
                        ctrl.clear = 1'b1;     // HALT
                        state_d    = SP_IDLE;
                    end
                end else if (tick_en) begin
                    ctrl.dec = 1'b1;
                end
            end
            default: state_d = SP_IDLE;
        endcase
    end

    assign running = (state_q == SP_RUN);

endmodule

// File: rtl/slot_pace_trigger.sv
module slot_pace_trigger
    import slot_pace_pkg::*;
#(
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_en,
    input  logic            cmd_start,
    input  logic            cmd_done,
    input  logic            fifo_nonempty,
    input  logic [LO_W-1:0] period_lo,
    input  logic            period_msb,
    output logic            send_start,
    output logic            slot_running
);

    localparam int CNT_W = LO_W + 1;

    cnt_ctrl_t        ctrl;
    logic [CNT_W-1:0] remain;
    logic             last;
    logic             period_ok;

    assign period_ok = |period_lo;

    slot_pace_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .cmd_start    (cmd_start),
        .cmd_done     (cmd_done),
        .fifo_nonempty(fifo_nonempty),
        .period_ok    (period_ok),
        .last         (last),
        .ctrl         (ctrl),
        .fire         (send_start),
        .running      (slot_running)
    );

    slot_pace_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .load_val({period_msb, period_lo}),
        .remain  (remain),
        .last    (last)
    );

endmodule

// File: rtl/slot_pace_checker.sv
module slot_pace_checker #(
    parameter int LO_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            tick_en,
    input logic            cmd_start,
    input logic            cmd_done,
    input logic            fifo_nonempty,
    input logic [LO_W-1:0] period_lo,
    input logic            send_start,
    input logic            slot_running
);

    AST_PULSE_NEEDS_FIFO: assert property (@(posedge clk) disable iff (rst)
        send_start |-> (fifo_nonempty && tick_en && slot_running)); // R5

    AST_ARM_NEEDS_PERIOD: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_running) |-> ($past(cmd_done) && $past(period_lo != '0))); // R2

    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !slot_running); // R11

    AST_ABORT_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> !send_start); // R11

    AST_DONE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> !send_start); // R12

    AST_ZERO_HALTS: assert property (@(posedge clk) disable iff (rst)
        (send_start && period_lo == '0) |=> !slot_running); // R10

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (slot_running && !tick_en && !cmd_start && !cmd_done) |=> slot_running); // R7

endmodule

bind slot_pace_trigger slot_pace_checker #(.LO_W(LO_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .cmd_start    (cmd_start),
    .cmd_done     (cmd_done),
    .fifo_nonempty(fifo_nonempty),
    .period_lo    (period_lo),
    .send_start   (send_start),
    .slot_running (slot_running)
);

// File: tb/slot_pace_trigger_bench.sv
module slot_pace_trigger_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en;
    logic       cmd_start;
    logic       cmd_done;
    logic       fifo_nonempty;
    logic [7:0] period_lo;
    logic       period_msb;
    logic       send_start;
    logic       slot_running;

    int    vectors   = 0;
    int    miscmp    = 0;
    bit    checking  = 0;
    bit    finished  = 0;
    string cur_req   = "R1";

    // behavioural reference state
    bit m_run  = 0;
    int m_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_pace_trigger u_slot_pace_trigger (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .cmd_start    (cmd_start),
        .cmd_done     (cmd_done),
        .fifo_nonempty(fifo_nonempty),
        .period_lo    (period_lo),
        .period_msb   (period_msb),
        .send_start   (send_start),
        .slot_running (slot_running)
    );

    // one clock: drive at negedge, compare, advance model, wait next negedge
    task automatic cyc(input bit t, input bit s, input bit d, input bit f);
        bit exp_send;
        int per;
        tick_en = t; cmd_start = s; cmd_done = d; fifo_nonempty = f;
        #1;
        exp_send = m_run && t && (m_left == 1) && f && !s && !d && !rst;
        if (checking) begin
            vectors++;
            if (send_start !== exp_send || slot_running !== m_run) begin
                miscmp++;
                $display("FAIL %s t=%0t send_start=%b expected %b slot_running=%b expected %b",
                         cur_req, $time, send_start, exp_send, slot_running, m_run);
            end
        end
        per = period_msb * 256 + period_lo;
        if (rst) begin
            m_run = 0; m_left = 0;
        end else if (s) begin
            m_run = 0; m_left = 0;
        end else if (d) begin
            if (period_lo != 0) begin m_run = 1; m_left = per; end
            else begin m_run = 0; m_left = 0; end
        end else if (m_run && t) begin
            if (m_left == 1) begin
                if (period_lo != 0) m_left = per;
                else begin m_run = 0; m_left = 0; end
            end else begin
                m_left--;
            end
        end
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n, input int every, input bit f);
        for (int i = 0; i < n; i++) cyc((i % every) == 0, 1'b0, 1'b0, f);
    endtask

    initial begin
        rst = 1'b1; tick_en = 0; cmd_start = 0; cmd_done = 0; fifo_nonempty = 0;
        period_lo = 8'd0; period_msb = 1'b0;
        @(negedge clk);
        cyc(1, 0, 0, 1);
        checking = 1;
        cur_req = "R1";                       // reset state
        cyc(1, 0, 0, 1);
        rst = 1'b0;
        run_ticks(3, 1, 1);

        cur_req = "R2";                       // zero low byte, msb set: stays idle
        period_lo = 8'd0; period_msb = 1'b1;
        cyc(1, 0, 1, 1);
        run_ticks(6, 1, 1);

        cur_req = "R3";                       // period 3, tick every cycle
        period_lo = 8'd3; period_msb = 1'b0;
        cyc(0, 0, 1, 1);
        cur_req = "R4";
        run_ticks(12, 1, 1);

        cur_req = "R5";                       // empty FIFO: no pulse
        run_ticks(7, 1, 0);
        cur_req = "R6";                       // still reloading
        run_ticks(7, 1, 1);

        cur_req = "R7";                       // sparse ticks
        run_ticks(25, 3, 1);

        cur_req = "R8";                       // rewrite mid-period
        cyc(1, 0, 0, 1);
        period_lo = 8'd5;
        run_ticks(20, 1, 1);

        cur_req = "R12";                      // restart by command completion
        run_ticks(2, 1, 1);
        period_lo = 8'd2;
        cyc(1, 0, 1, 1);
        run_ticks(8, 1, 1);

        cur_req = "R11";                      // start overrides done
        cyc(1, 1, 1, 1);
        run_ticks(5, 1, 1);
        cyc(1, 0, 1, 1);                      // arm with period 2
        cyc(1, 0, 0, 1);
        cyc(1, 1, 0, 1);                      // start on the terminal tick
        run_ticks(4, 1, 1);

        cur_req = "R9";                       // msb adds 256: period 257
        period_lo = 8'd1; period_msb = 1'b1;
        cyc(1, 0, 1, 1);
        run_ticks(520, 1, 1);
        period_lo = 8'hBF;                    // 0x1BF = 447
        cyc(1, 0, 1, 1);
        run_ticks(900, 1, 1);

        cur_req = "R10";                      // zero low byte stops at reload
        period_lo = 8'd4; period_msb = 1'b0;
        cyc(1, 0, 1, 1);
        run_ticks(2, 1, 1);
        period_lo = 8'd0;
        run_ticks(12, 1, 1);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            miscmp++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

endmodule